// File: doc/BRIEF.md
# Renaming Reorder Buffer with Parallel Operand Search

This block gives every decoded instruction its own temporary result slot in a circular buffer of `DEPTH` entries (ten by default), so that two in-flight writes to one architectural register never share storage. The slot number, or tag, is handed back at allocation time. Later instructions use it in place of the architectural register name. Execution units return results by tag. Completed entries drain from the oldest end into the architectural register file, strictly in program order.

Each cycle, a source-operand port compares one architectural register number against the destination field of every occupied slot at the same time. If several slots match, the youngest one wins. The registered answer says one of three things: the value is held only in the register file, the value is still being computed (the producer's tag is returned), or the value is ready (the value and tag are returned). A flush input discards every in-flight slot in a single cycle.

Top module: `rob_rename_core`

## Requirements
- R1: After synchronous reset, `alloc_tag` is 0, `alloc_stall` is 0, `ret_valid` is 0 and `lk_status` is 2'b00.
- R2: An accepted allocation takes the slot shown on `alloc_tag` during that cycle, and the next slot number follows it, wrapping from `DEPTH-1` to 0. Every allocation takes a new slot, even when a slot already in flight targets the same architectural register.
- R3: `alloc_stall` is 1 exactly when all `DEPTH` slots are occupied. A request made while it is 1 is refused and `alloc_tag` does not move. This holds even when the oldest slot retires on the same edge.
- R4: A writeback to an occupied slot marks it ready and stores `wb_data`. A writeback to a free slot, or to a tag of `DEPTH` or more, has no effect. In particular, a later allocation of that slot still reads as pending.
- R5: The lookup result is registered. It reflects slot contents as they stood before the updates made at the same edge. `lk_status` is 2'b00 when no occupied slot matches. It is 2'b01 when the chosen slot is not ready, with `lk_tag` set to that slot and `lk_data` set to 0. It is 2'b10 when the chosen slot is ready, with `lk_tag` set to the slot and `lk_data` set to its value.
- R6: When several occupied slots hold the requested register, the lookup picks the one allocated most recently.
- R7: Only the oldest slot retires, and only on an edge where it is already ready. At that edge, `ret_valid` pulses for one cycle with that slot's destination and value, and the slot is freed. Retirements appear in allocation order.
- R8: An accepted allocation and a retirement on the same edge leave the occupancy unchanged.
- R9: A flush clears every slot and resets both ends to slot 0 in one cycle. It overrides an allocation made in the same cycle. After it, `ret_valid` is 0 and `lk_status` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all in-flight slots |
| alloc_req | input | 1 | Request a slot for a decoded instruction |
| alloc_areg | input | AREG_W | Architectural destination of that instruction |
| alloc_tag | output | TAG_W | Slot granted to a request in this cycle |
| alloc_stall | output | 1 | Buffer full, request refused |
| wb_en | input | 1 | Result writeback strobe |
| wb_tag | input | TAG_W | Slot receiving the result |
| wb_data | input | DATA_W | Result value |
| lk_areg | input | AREG_W | Architectural source register to search for |
| lk_status | output | 2 | 00 register file, 01 pending, 10 value ready |
| lk_tag | output | TAG_W | Slot that matched |
| lk_data | output | DATA_W | Matched value when ready, else 0 |
| ret_valid | output | 1 | A slot retired on the last edge |
| ret_areg | output | AREG_W | Destination of the retired slot |
| ret_data | output | DATA_W | Value of the retired slot |

## Verification
The hardest case to reach is a full buffer whose oldest slot retires on the same edge that a new request arrives. Getting there takes ten allocations with no writebacks, so that the read and write ends wrap onto the same slot. One writeback then makes only the oldest slot ready, and the request is presented in the cycle after. The stimulus then repeats the collision one slot further on, with one free slot, to show the occupancy holding steady. A writeback is also aimed at a free slot that is allocated two cycles later, to show that a stale ready bit never leaks into a new instruction.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Encoding of the operand search result
  typedef enum logic [1:0] {
    LK_REGFILE = 2'b00,
    LK_PENDING = 2'b01,
    LK_VALUE   = 2'b10
  } lk_status_e;

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 10,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             alloc_req,
  input  logic             retire_fire,
  output logic             alloc_fire,
  output logic             full,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count
);

  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  function automatic logic [TAG_W-1:0] step_ptr(input logic [TAG_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full       = (count == CNT_W'(DEPTH));
  assign alloc_fire = alloc_req && !full && !flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (alloc_fire)  tail <= step_ptr(tail);
      if (retire_fire) head <= step_ptr(head);
      case ({alloc_fire, retire_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  assert_tail_wrap_R2: assert property (@(posedge clk) disable iff (rst || flush)
    (alloc_fire && tail == LAST) |=> (tail == '0));

  assert_stall_holds_tail_R3: assert property (@(posedge clk) disable iff (rst || flush)
    (alloc_req && full) |=> $stable(tail));

endmodule

// File: rtl/rob_cam_lookup.sv
module rob_cam_lookup #(
  parameter int DEPTH  = 10,
  parameter int AREG_W = 5,
  parameter int TAG_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TAG_W-1:0]  head,
  input  logic [DEPTH-1:0]  ent_valid,
  input  logic [AREG_W-1:0] ent_dest [DEPTH],
  input  logic [AREG_W-1:0] lk_areg,
  output logic              hit,
  output logic [TAG_W-1:0]  sel
);

  // Every slot is compared at once; walking from oldest to youngest
  // lets the later (younger) match override earlier ones.
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int idx;
      idx = int'(head) + k;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if (ent_valid[idx] && ent_dest[idx] == lk_areg) begin
        hit = 1'b1;
        sel = TAG_W'(idx);
      end
    end
  end

  assert_hit_valid_R6: assert property (@(posedge clk) disable iff (rst)
    hit |-> (ent_valid[sel] && ent_dest[sel] == lk_areg));

endmodule

// File: rtl/rob_rename_core.sv
module rob_rename_core #(
  parameter int DEPTH  = 10,
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  parameter int TAG_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              alloc_req,
  input  logic [AREG_W-1:0] alloc_areg,
  output logic [TAG_W-1:0]  alloc_tag,
  output logic              alloc_stall,
  input  logic              wb_en,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [AREG_W-1:0] lk_areg,
  output logic [1:0]        lk_status,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [DATA_W-1:0] lk_data,
  output logic              ret_valid,
  output logic [AREG_W-1:0] ret_areg,
  output logic [DATA_W-1:0] ret_data
);
  import rob_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  ent_valid;
  logic [DEPTH-1:0]  ent_ready;
  logic [AREG_W-1:0] ent_dest [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];

  logic              alloc_fire;
  logic              retire_fire;
  logic              full;
  logic [TAG_W-1:0]  head;
  logic [TAG_W-1:0]  tail;
  logic [CNT_W-1:0]  count;
  logic              cam_hit;
  logic [TAG_W-1:0]  cam_sel;
  logic              wb_hit;

  assign retire_fire = ent_valid[head] && ent_ready[head] && !flush;
  assign wb_hit      = wb_en && (int'(wb_tag) < DEPTH) && ent_valid[wb_tag];
  assign alloc_tag   = tail;
  assign alloc_stall = full;

  rob_ptr_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) ptr_i (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .alloc_req   (alloc_req),
    .retire_fire (retire_fire),
    .alloc_fire  (alloc_fire),
    .full        (full),
    .head        (head),
    .tail        (tail),
    .count       (count)
  );

  rob_cam_lookup #(.DEPTH(DEPTH), .AREG_W(AREG_W), .TAG_W(TAG_W)) cam_i (
    .clk       (clk),
    .rst       (rst),
    .head      (head),
    .ent_valid (ent_valid),
    .ent_dest  (ent_dest),
    .lk_areg   (lk_areg),
    .hit       (cam_hit),
    .sel       (cam_sel)
  );

  // Per-slot state bits
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ent_valid <= '0;
      ent_ready <= '0;
    end else begin
      if (wb_hit) ent_ready[wb_tag] <= 1'b1;
      if (retire_fire) ent_valid[head] <= 1'b0;
      if (alloc_fire) begin
        ent_valid[tail] <= 1'b1;
        ent_ready[tail] <= 1'b0;
      end
    end
  end

  // Payload storage, no reset
  always_ff @(posedge clk) begin
    if (alloc_fire) ent_dest[tail]  <= alloc_areg;
    if (wb_hit)     ent_data[wb_tag] <= wb_data;
  end

  // Registered lookup answer
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      lk_status <= LK_REGFILE;
      lk_tag    <= '0;
      lk_data   <= '0;
    end else begin
      lk_tag <= cam_sel;
      if (!cam_hit) begin
        lk_status <= LK_REGFILE;
        lk_data   <= '0;
      end else if (ent_ready[cam_sel]) begin
        lk_status <= LK_VALUE;
        lk_data   <= ent_data[cam_sel];
      end else begin
        lk_status <= LK_PENDING;
        lk_data   <= '0;
      end
    end
  end

  // Registered retirement port
  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid <= 1'b0;
      ret_areg  <= '0;
      ret_data  <= '0;
    end else begin
      ret_valid <= retire_fire;
      ret_areg  <= ent_dest[head];
      ret_data  <= ent_data[head];
    end
  end

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0 && !ret_valid && lk_status == LK_REGFILE));

  assert_retire_needs_ready_R7: assert property (@(posedge clk) disable iff (rst || flush)
    (ent_valid[head] && !ent_ready[head]) |=> !ret_valid);

  assert_wb_free_ignored_R4: assert property (@(posedge clk) disable iff (rst || flush)
    (wb_en && int'(wb_tag) < DEPTH && !ent_valid[wb_tag]) |=> !ent_ready[$past(wb_tag)]);

endmodule

// File: tb/rob_rename_core_tb_top.sv
module rob_rename_core_tb_top;
  localparam int DEPTH  = 10;
  localparam int AREG_W = 5;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 4;

  logic              clk = 1'b0;
  logic              rst, flush, alloc_req, wb_en;
  logic [AREG_W-1:0] alloc_areg, lk_areg;
  logic [TAG_W-1:0]  alloc_tag, wb_tag, lk_tag;
  logic              alloc_stall, ret_valid;
  logic [DATA_W-1:0] wb_data, lk_data, ret_data;
  logic [1:0]        lk_status;
  logic [AREG_W-1:0] ret_areg;

  always #5 clk = ~clk;

  rob_rename_core #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst(rst), .flush(flush),
    .alloc_req(alloc_req), .alloc_areg(alloc_areg), .alloc_tag(alloc_tag), .alloc_stall(alloc_stall),
    .wb_en(wb_en), .wb_tag(wb_tag), .wb_data(wb_data),
    .lk_areg(lk_areg), .lk_status(lk_status), .lk_tag(lk_tag), .lk_data(lk_data),
    .ret_valid(ret_valid), .ret_areg(ret_areg), .ret_data(ret_data)
  );

  typedef struct { logic [AREG_W-1:0] a; logic [DATA_W-1:0] d; } exp_t;
  exp_t exp_q[$];
  int vecs = 0;
  int errs = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    alloc_req = 1'b0;
    wb_en     = 1'b0;
    flush     = 1'b0;
  endtask

  // Driver: requests a slot and queues the expected retirement
  task automatic do_alloc(input logic [AREG_W-1:0] a, input logic [DATA_W-1:0] d,
                          input bit push, output logic [TAG_W-1:0] t);
    alloc_req  = 1'b1;
    alloc_areg = a;
    t = alloc_tag;
    if (push) exp_q.push_back('{a: a, d: d});
  endtask

  task automatic do_wb(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
    wb_en = 1'b1; wb_tag = t; wb_data = d;
  endtask

  // Monitor: compares each retirement against the scoreboard
  always @(negedge clk) begin
    if (!rst && ret_valid) begin
      if (exp_q.size() == 0) begin
        vecs++; errs++;
        $display("FAIL R7 unexpected retirement actual=%0h expected=none", ret_areg);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R7 retired areg", 32'(ret_areg), 32'(e.a));
        chk("R7 retired data", ret_data, e.d);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vecs++; errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [TAG_W-1:0] t;
    rst = 1'b1; flush = 1'b0; alloc_req = 1'b0; wb_en = 1'b0;
    alloc_areg = '0; wb_tag = '0; wb_data = '0; lk_areg = 5'd3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    chk("R1 alloc_tag", 32'(alloc_tag), 0);
    chk("R1 alloc_stall", 32'(alloc_stall), 0);
    chk("R1 ret_valid", 32'(ret_valid), 0);
    chk("R1 lk_status", 32'(lk_status), 0);

    // Two writers of register 5, then one of register 7
    do_alloc(5, 32'h1111, 1, t); tick(); chk("R2 first tag", 32'(t), 0);
    do_alloc(5, 32'hAAAA, 1, t); tick(); chk("R2 second tag same areg", 32'(t), 1);
    do_alloc(7, 32'h2222, 1, t); lk_areg = 5; tick(); chk("R2 third tag", 32'(t), 2);
    chk("R6 youngest pending status", 32'(lk_status), 1);
    chk("R6 youngest tag", 32'(lk_tag), 1);
    lk_areg = 9; tick();
    chk("R5 no match status", 32'(lk_status), 0);

    // Writeback of the younger producer
    do_wb(1, 32'hAAAA); lk_areg = 5; tick();
    chk("R5 pre-update view", 32'(lk_status), 1);
    tick();
    chk("R5 value status", 32'(lk_status), 2);
    chk("R4 value data", lk_data, 32'hAAAA);
    chk("R5 value tag", 32'(lk_tag), 1);
    chk("R7 head not ready", 32'(ret_valid), 0);

    // Oldest becomes ready: in-order drain of tags 0 and 1
    do_wb(0, 32'h1111); tick();
    chk("R7 no retire on ready edge", 32'(ret_valid), 0);
    tick(); chk("R7 retire tag0", 32'(ret_valid), 1);
    tick(); chk("R7 retire tag1", 32'(ret_valid), 1);
    tick(); chk("R7 tag2 waits", 32'(ret_valid), 0);
    chk("R5 freed areg reads regfile", 32'(lk_status), 0);
    lk_areg = 7; tick();
    chk("R5 pending status", 32'(lk_status), 1);
    chk("R5 pending tag", 32'(lk_tag), 2);
    chk("R5 pending data zero", lk_data, 0);

    // Writeback to a free slot must not stick
    do_wb(4, 32'hDEAD); tick();
    do_alloc(11, 32'h3333, 1, t); tick(); chk("R2 tag3", 32'(t), 3);
    do_alloc(12, 32'h4444, 1, t); tick(); chk("R2 tag4", 32'(t), 4);
    lk_areg = 12; tick(); tick();
    chk("R4 stale wb ignored status", 32'(lk_status), 1);
    chk("R4 stale wb ignored tag", 32'(lk_tag), 4);
    do_wb(2, 32'h2222); tick();
    do_wb(3, 32'h3333); tick();
    do_wb(4, 32'h4444); tick();
    repeat (3) tick();
    chk("R7 queue drained", exp_q.size(), 0);

    // Fill all slots across the wrap
    for (int i = 0; i < DEPTH; i++) begin
      do_alloc(5'(i + 1), 32'h100 + i, 1, t); tick();
      chk("R2 wrap order", 32'(t), (5 + i) % DEPTH);
    end
    chk("R3 stall when full", 32'(alloc_stall), 1);
    alloc_req = 1'b1; alloc_areg = 5'd30; tick();
    chk("R3 refused tail", 32'(alloc_tag), 5);
    chk("R3 still full", 32'(alloc_stall), 1);

    // Request on the same edge as a retirement from a full buffer
    do_wb(5, 32'h100); tick();
    alloc_req = 1'b1; alloc_areg = 5'd30; tick();
    chk("R3 refused during retire stall", 32'(alloc_stall), 0);
    chk("R3 refused during retire tag", 32'(alloc_tag), 5);

    // Allocation and retirement together keep the count
    do_wb(6, 32'h101); tick();
    do_alloc(20, 32'h200, 1, t); tick();
    chk("R8 slot taken", 32'(t), 5);
    chk("R8 count held, no stall", 32'(alloc_stall), 0);
    chk("R8 next tag", 32'(alloc_tag), 6);
    do_alloc(21, 32'h201, 1, t); tick();
    chk("R8 full again", 32'(alloc_stall), 1);

    // Flush with a concurrent request
    exp_q.delete();
    flush = 1'b1; alloc_req = 1'b1; alloc_areg = 5'd9; tick();
    chk("R9 tail reset", 32'(alloc_tag), 0);
    chk("R9 not full", 32'(alloc_stall), 0);
    chk("R9 lookup cleared", 32'(lk_status), 0);
    chk("R9 no retire", 32'(ret_valid), 0);
    do_wb(7, 32'hBAD); tick();
    do_alloc(3, 32'h300, 1, t); lk_areg = 3; tick();
    chk("R9 first tag after flush", 32'(t), 0);
    tick();
    chk("R9 only new entry matches", 32'(lk_status), 1);
    chk("R9 new entry tag", 32'(lk_tag), 0);
    do_wb(0, 32'h300); tick();
    repeat (3) tick();
    chk("R9 queue drained", exp_q.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule